// File: doc/BRIEF.md
# SPI Master with Delayed Receive Sampling

This block is a single-slave SPI master that moves one 8-bit word out and one 8-bit word in per transfer, MSB first. The user presents a parallel word and pulses a start strobe. The block then lowers chip select, waits a programmable lead time, runs sixteen SCK transitions and waits a programmable trail time. It then raises chip select and pulses done. The received word is valid on the cycle of the done pulse.

The data format is always the one in which both sides launch data on the first SCK transition after idle. In the standard sampling mode the master captures MISO on every even-numbered transition. In the delayed sampling mode the master captures MISO on odd-numbered transitions from the third one onward. It captures the final bit half an SCK period after the sixteenth transition, and SCK does not move for that capture. This gives a slow slave almost a full SCK period, rather than half of one, to present each bit. Transitions are numbered from 1, starting with the first move of SCK away from its idle level.

The SCK period is a programmable number of system clocks (even, minimum 4). SCK idles at the clock polarity input. Configuration is captured when the start strobe is accepted.

Top module: `spi_late_master`

## Requirements
- R1: After reset, cs_no is 1, done_o is 0, mosi_o is 0 and sck_o equals cpol_i.
- R2: The first SCK transition occurs max(lead_dly_i,1) + div_i/2 system clocks after cs_no falls, and SCK does not move in the cycle right after the fall.
- R3: While cs_no is low, SCK makes exactly 16 transitions, spaced div_i/2 system clocks apart. While cs_no is high, sck_o equals cpol_i.
- R4: mosi_o carries tx_data_i MSB first. Bit 7-k is launched on transition 2k+1, so a slave sampling on even transitions receives tx_data_i. mosi_o changes only on SCK transitions while cs_no is low.
- R5: With late_smp_i=0, MISO is captured on even transitions. A slave that updates MISO up to div_i/2-1 system clocks after its launching transition is received correctly, MSB first.
- R6: With late_smp_i=1, MISO is captured on transitions 3,5,...,15, and the last bit is captured div_i/2 clocks after transition 16 with no SCK movement. A slave that updates MISO up to div_i-1 clocks after its launching transition is received correctly.
- R7: cs_no rises T clocks after transition 16. T is max(trail_dly_i,1) in standard mode and max(trail_dly_i,div_i/2) in delayed mode.
- R8: done_o is high for exactly one clock per transfer, in the first clock where cs_no is high again, and rx_data_o holds the received word then.
- R9: A start_i pulse while a transfer is in progress is ignored. No second chip-select cycle occurs, and the words moved in both directions are unchanged. cs_no only falls on a cycle after start_i was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| tx_data_i | input | 8 | Word to transmit |
| cpol_i | input | 1 | SCK idle level |
| late_smp_i | input | 1 | 1 selects delayed receive sampling |
| div_i | input | 8 | SCK period in system clocks (even, at least 4) |
| lead_dly_i | input | 8 | Chip-select-to-SCK delay in system clocks |
| trail_dly_i | input | 8 | Last-SCK-to-chip-select delay in system clocks |
| miso_i | input | 1 | Serial data from slave |
| cs_no | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to slave |
| rx_data_o | output | 8 | Received word |
| done_o | output | 1 | One-clock transfer complete strobe |

## Verification
The bench slave delays its MISO updates by the largest amount each mode must tolerate: div/2-1 clocks in standard mode and div-1 clocks in delayed mode. A master that sampled on the wrong transition parity, or that skipped or misplaced the final untoggled capture, would return a word that is shifted or has a corrupted LSB. The smallest divider of 4 is combined with a zero trail delay in delayed mode. A design that failed to stretch the trail to half a period would raise chip select before the final capture, so the measured trail time would be wrong. A second start pulse injected mid-transfer would, in a faulty design, produce a second chip-select fall or a corrupted word.

// File: rtl/spi_late_pkg.sv
package spi_late_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_XFER  = 2'd2,
    ST_TRAIL = 2'd3
  } xfer_state_e;
endpackage

// File: rtl/spi_late_ctrl.sv
module spi_late_ctrl
  import spi_late_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned DLY_W  = 8,
  parameter int unsigned EDGE_W = $clog2(2 * DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              late_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DLY_W-1:0]  lead_dly_i,
  input  logic [DLY_W-1:0]  trail_dly_i,
  output logic              cs_n_o,
  output logic              phase_o,
  output logic              load_o,
  output logic              tick_o,
  output logic [EDGE_W-1:0] edge_num_o,
  output logic              late_o,
  output logic              tail_smp_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = ((DIV_W > DLY_W) ? DIV_W : DLY_W) + 1;
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W);

  xfer_state_e       state_q;
  logic [DIV_W-1:0]  div_q;
  logic [DLY_W-1:0]  lead_q, trail_q;
  logic              late_q;
  logic [CNT_W-1:0]  hcnt_q, dcnt_q;
  logic [CNT_W-1:0]  half_w, lead_w, trail_w;
  logic [EDGE_W-1:0] edge_q;

  always_comb begin
    half_w  = (div_q < DIV_W'(4)) ? CNT_W'(2) : CNT_W'(div_q >> 1);
    lead_w  = (lead_q == '0) ? CNT_W'(1) : CNT_W'(lead_q);
    trail_w = (trail_q == '0) ? CNT_W'(1) : CNT_W'(trail_q);
    // delayed capture must land before chip select releases
    if (late_q && (trail_w < half_w)) trail_w = half_w;
  end

  assign load_o     = (state_q == ST_IDLE) && start_i;
  assign tick_o     = (state_q == ST_XFER) && (hcnt_q == '0);
  assign edge_num_o = edge_q + 1'b1;
  assign late_o     = late_q;
  assign tail_smp_o = (state_q == ST_TRAIL) && late_q && (dcnt_q == half_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_n_o  <= 1'b1;
      phase_o <= 1'b0;
      done_o  <= 1'b0;
      hcnt_q  <= '0;
      dcnt_q  <= '0;
      edge_q  <= '0;
      div_q   <= DIV_W'(4);
      lead_q  <= '0;
      trail_q <= '0;
      late_q  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_LEAD;
            cs_n_o  <= 1'b0;
            phase_o <= 1'b0;
            dcnt_q  <= CNT_W'(1);
            div_q   <= div_i;
            lead_q  <= lead_dly_i;
            trail_q <= trail_dly_i;
            late_q  <= late_i;
          end
        end
        ST_LEAD: begin
          if (dcnt_q >= lead_w) begin
            state_q <= ST_XFER;
            hcnt_q  <= half_w - 1'b1;
            edge_q  <= '0;
          end else begin
            dcnt_q <= dcnt_q + 1'b1;
          end
        end
        ST_XFER: begin
          if (hcnt_q == '0) begin
            phase_o <= ~phase_o;
            edge_q  <= edge_num_o;
            hcnt_q  <= half_w - 1'b1;
            if (edge_num_o == LAST_EDGE) begin
              state_q <= ST_TRAIL;
              dcnt_q  <= CNT_W'(1);
            end
          end else begin
            hcnt_q <= hcnt_q - 1'b1;
          end
        end
        ST_TRAIL: begin
          if (dcnt_q >= trail_w) begin
            state_q <= ST_IDLE;
            cs_n_o  <= 1'b1;
            done_o  <= 1'b1;
          end else begin
            dcnt_q <= dcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_late_tx.sv
module spi_late_tx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EDGE_W = $clog2(2 * DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              idle_i,
  input  logic              tick_i,
  input  logic [EDGE_W-1:0] edge_num_i,
  output logic              mosi_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      mosi_o <= 1'b0;
    end else if (load_i) begin
      sh_q   <= data_i;
      mosi_o <= 1'b0;
    end else if (idle_i) begin
      mosi_o <= 1'b0;
    end else if (tick_i && edge_num_i[0]) begin
      mosi_o <= sh_q[DATA_W-1];
      sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_late_rx.sv
module spi_late_rx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EDGE_W = $clog2(2 * DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              tick_i,
  input  logic [EDGE_W-1:0] edge_num_i,
  input  logic              late_i,
  input  logic              tail_i,
  input  logic              miso_i,
  output logic [DATA_W-1:0] data_o
);
  logic odd_edge, smp;

  assign odd_edge = edge_num_i[0];
  // delayed mode: odd edges from 3 on, plus one untoggled tail capture
  assign smp = tail_i
             | (tick_i & (late_i ? (odd_edge && (edge_num_i >= EDGE_W'(3))) : !odd_edge));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_o <= '0;
    else if (load_i) data_o <= '0;
    else if (smp)    data_o <= {data_o[DATA_W-2:0], miso_i};
  end
endmodule

// File: rtl/spi_late_master.sv
module spi_late_master #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned DLY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              cpol_i,
  input  logic              late_smp_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DLY_W-1:0]  lead_dly_i,
  input  logic [DLY_W-1:0]  trail_dly_i,
  input  logic              miso_i,
  output logic              cs_no,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o
);
  localparam int unsigned EDGE_W = $clog2(2 * DATA_W + 1);

  logic              phase, load, tick, late, tail_smp, cpol_q;
  logic [EDGE_W-1:0] edge_num;

  spi_late_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DLY_W(DLY_W), .EDGE_W(EDGE_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .late_i(late_smp_i), .div_i, .lead_dly_i, .trail_dly_i,
    .cs_n_o(cs_no), .phase_o(phase), .load_o(load), .tick_o(tick),
    .edge_num_o(edge_num), .late_o(late), .tail_smp_o(tail_smp), .done_o
  );

  spi_late_tx #(.DATA_W(DATA_W), .EDGE_W(EDGE_W)) u_tx (
    .clk_i, .rst_ni, .load_i(load), .data_i(tx_data_i), .idle_i(cs_no),
    .tick_i(tick), .edge_num_i(edge_num), .mosi_o
  );

  spi_late_rx #(.DATA_W(DATA_W), .EDGE_W(EDGE_W)) u_rx (
    .clk_i, .rst_ni, .load_i(load), .tick_i(tick), .edge_num_i(edge_num),
    .late_i(late), .tail_i(tail_smp), .miso_i, .data_o(rx_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cpol_q <= 1'b0;
    else if (load) cpol_q <= cpol_i;
  end

  assign sck_o = (cs_no ? cpol_i : cpol_q) ^ phase;
endmodule

// File: rtl/spi_late_master_chk.sv
module spi_late_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cpol_i,
  input logic cs_no,
  input logic sck_o,
  input logic mosi_o,
  input logic done_o
);
  a_r3_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (sck_o == cpol_i));
  a_r2_lead_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |=> $stable(sck_o));
  a_r4_mosi_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no) && $stable(sck_o)) |-> $stable(mosi_o));
  a_r8_done_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_no);
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_cs_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(start_i));
endmodule

bind spi_late_master spi_late_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cpol_i(cpol_i),
  .cs_no(cs_no), .sck_o(sck_o), .mosi_o(mosi_o), .done_o(done_o)
);

// File: tb/spi_late_master_bench.sv
`timescale 1ns/1ps
module spi_late_master_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start = 1'b0;
  logic [7:0] tx_data = '0;
  logic       cpol = 1'b0;
  logic       late = 1'b0;
  logic [7:0] div = 8'd4;
  logic [7:0] lead_dly = '0;
  logic [7:0] trail_dly = '0;
  logic       miso = 1'b0;
  logic       cs_n, sck, mosi, done;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  spi_late_master u_spi_late_master (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .tx_data_i(tx_data),
    .cpol_i(cpol), .late_smp_i(late), .div_i(div), .lead_dly_i(lead_dly),
    .trail_dly_i(trail_dly), .miso_i(miso), .cs_no(cs_n), .sck_o(sck),
    .mosi_o(mosi), .rx_data_o(rx_data), .done_o(done)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave model and pin monitor
  logic       sck_prev = 1'b0, cs_prev = 1'b1;
  logic [7:0] slv_tx = '0, slv_rx = '0, rx_at_done = '0;
  logic       miso_next = 1'b0, done_cs_ok = 1'b0;
  int edge_cnt = 0, t_csfall = 0, t_first = 0, t_last = 0, t_csrise = 0;
  int gap_err = 0, done_cnt = 0, cs_falls = 0, idle_err = 0;
  int miso_dly = 0, pend = 0, half = 2;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (pend > 0) begin
        pend--;
        if (pend == 0) miso = miso_next;
      end
      if (cs_prev && !cs_n) begin
        t_csfall = cyc; edge_cnt = 0; cs_falls++; pend = 0;
      end
      if (cs_n && (sck != cpol)) idle_err++;
      if (!cs_n && (sck != sck_prev)) begin
        edge_cnt++;
        if (edge_cnt == 1) t_first = cyc;
        else if (cyc - t_last != half) gap_err++;
        t_last = cyc;
        if (edge_cnt % 2 == 1) begin
          if (miso_dly == 0) miso = slv_tx[7 - (edge_cnt - 1) / 2];
          else begin
            miso_next = slv_tx[7 - (edge_cnt - 1) / 2];
            pend = miso_dly;
          end
        end else begin
          slv_rx = {slv_rx[6:0], mosi};
        end
      end
      if (!cs_prev && cs_n) t_csrise = cyc;
      if (done) begin
        done_cnt++; done_cs_ok = cs_n; rx_at_done = rx_data;
      end
    end
    sck_prev = sck;
    cs_prev = cs_n;
  end

  task automatic run(input logic [7:0] txw, input logic [7:0] sw, input bit pol,
                     input bit lt, input int dv, input int lead, input int trail,
                     input bit poke);
    int exp_lead, exp_trail, waited;
    @(posedge clk); #2;
    cpol = pol; late = lt; div = 8'(dv); lead_dly = 8'(lead); trail_dly = 8'(trail);
    half = dv / 2;
    miso_dly = lt ? dv - 1 : half - 1;
    slv_tx = sw; slv_rx = '0; done_cnt = 0; cs_falls = 0; gap_err = 0; idle_err = 0;
    @(posedge clk); #2;
    tx_data = txw; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    if (poke) begin
      repeat (3 * dv) @(posedge clk);
      #2; tx_data = ~txw; cpol = ~pol; start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0; tx_data = txw; cpol = pol;
    end
    waited = 0;
    while (done_cnt == 0 && waited < 3000) begin
      @(posedge clk); waited++;
    end
    repeat (3) @(posedge clk);
    exp_lead  = ((lead == 0) ? 1 : lead) + half;
    exp_trail = (trail == 0) ? 1 : trail;
    if (lt && exp_trail < half) exp_trail = half;
    chk(t_first - t_csfall == exp_lead, "R2 lead time", t_first - t_csfall, exp_lead);
    chk(edge_cnt == 16 && gap_err == 0, "R3 edge count/spacing", edge_cnt, 16);
    chk(idle_err == 0, "R3 idle level", idle_err, 0);
    chk(slv_rx == txw, "R4 slave received", slv_rx, txw);
    if (lt) chk(rx_at_done == sw, "R6 delayed capture word", rx_at_done, sw);
    else    chk(rx_at_done == sw, "R5 standard capture word", rx_at_done, sw);
    chk(t_csrise - t_last == exp_trail, "R7 trail time", t_csrise - t_last, exp_trail);
    chk(done_cnt == 1 && done_cs_ok, "R8 done pulse", done_cnt, 1);
    if (poke) chk(cs_falls == 1, "R9 start ignored while busy", cs_falls, 1);
  endtask

  initial begin
    #(20 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk(cs_n == 1'b1, "R1 reset cs_no", cs_n, 1);
    chk(done == 1'b0, "R1 reset done_o", done, 0);
    chk(mosi == 1'b0, "R1 reset mosi_o", mosi, 0);
    chk(sck == cpol, "R1 reset sck_o", sck, cpol);
    #2 rst_ni = 1'b1;

    // configuration sweep
    for (int p = 0; p < 4; p++)
      for (int pol = 0; pol < 2; pol++)
        for (int lt = 0; lt < 2; lt++)
          for (int dv = 4; dv <= 6; dv += 2)
            for (int ld = 0; ld <= 3; ld += 3)
              for (int tr = 0; tr <= 5; tr += 5)
                run(8'((p * 73 + 19) & 255), 8'((p * 151 + 106) & 255),
                    pol[0], lt[0], dv, ld, tr, 1'b0);

    // exhaustive data at the fastest rate, delayed mode, tightest trail
    for (int v = 0; v < 256; v++)
      run(8'(v), ~8'(v), 1'b0, 1'b1, 4, 1, 0, 1'b0);

    // start strobes during a busy transfer
    run(8'hA5, 8'h3C, 1'b0, 1'b1, 4, 2, 0, 1'b1);
    run(8'h5A, 8'hC3, 1'b1, 1'b0, 6, 0, 4, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule